// File: doc/BRIEF.md
# Transmit Jabber Watchdog

This block guards a transmitter against a runaway transmit-active indication. It samples the transmit-active level on every clock edge and counts how many consecutive samples have been high. If the run goes past a configured limit, the watchdog trips. It then pulls its transmit-enable gate low for a fixed lockout period and raises a single-cycle event that a separate status register can latch as a sticky jabber flag.

Both durations are parameters in clock cycles. By default they are derived from the clock frequency: a 2 ms continuous-transmit limit and a 16 ms forced-off period. When the lockout ends the gate reopens by itself. If transmit-active is still high at that point, the watchdog waits in a holding state until it sees a low sample before it arms again. A stuck-high input therefore produces one event, not a stream of them.

The controller has four states:
- ARMED: idle and waiting for transmit activity.
- COUNTING: measuring a transmit run.
- LOCKOUT: transmitter forced off.
- HOLDOFF: gate open, waiting for a low sample.

It has six named transitions:
- START: ARMED to COUNTING, on a high sample.
- ABORT: COUNTING to ARMED, on a low sample before the limit.
- TRIP: COUNTING to LOCKOUT, on the high sample after the limit.
- RELEASE: LOCKOUT to ARMED, at the end of the lockout with the input low.
- PARK: LOCKOUT to HOLDOFF, at the end of the lockout with the input still high.
- REARM: HOLDOFF to ARMED, on a low sample.

Top module: `tx_jabber_watchdog`

## Requirements
- R1: While reset is asserted, and after it is released, tx_enable is 1 and jabber_evt is 0, and the controller is ARMED; a reset during LOCKOUT reopens the gate at once.
- R2: A run of at most LIMIT_CYC consecutive high samples of tx_active never trips: tx_enable stays 1 and jabber_evt stays 0.
- R3: The sample that makes a run LIMIT_CYC+1 long trips the watchdog; tx_enable reads 0 from the cycle after that clock edge.
- R4: jabber_evt is 1 for exactly one cycle per trip, and that is the first cycle in which tx_enable is 0.
- R5: tx_enable stays 0 for exactly LOCK_CYC cycles after a trip, whatever tx_active does, and then returns to 1.
- R6: A single low sample before the limit restarts the count from zero, so two runs of LIMIT_CYC separated by one low sample do not trip.
- R7: If tx_active is still high when the lockout ends, no further trip happens until a low sample is seen; one low sample re-arms the watchdog, and the next run of LIMIT_CYC+1 high samples trips again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_active | input | 1 | Transmit-active level from the coding sublayer |
| tx_enable | output | 1 | Transmit gate; 0 only during lockout |
| jabber_evt | output | 1 | One-cycle pulse at the start of each lockout |

## Verification
The assertions assume that tx_active is synchronous to clk and settled at each rising edge. They also assume that the checker's run-length and off-time counters begin at the same reset as the design, so that "consecutive high samples" means the same thing on both sides. The bench changes tx_active only on falling edges and asserts reset from time zero. It sweeps burst lengths from one sample up to well past the limit plus the lockout, each followed by a low gap long enough for the lockout to finish. It also runs short-gap sequences and a reset issued during lockout. In every case the expected gate and event values are derived from the burst length and the cycle index alone.

// File: rtl/jabwd_pkg.sv
package jabwd_pkg;

    typedef enum logic [1:0] {
        ST_ARMED    = 2'd0,
        ST_COUNTING = 2'd1,
        ST_LOCKOUT  = 2'd2,
        ST_HOLDOFF  = 2'd3
    } jab_state_e;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int bits_for(input int v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

endpackage

// File: rtl/jabwd_span_counter.sv
module jabwd_span_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_one,
    input  logic             clear,
    input  logic             step,
    output logic [CNT_W-1:0] count
);

    // One counter serves both timed phases; the controller decides what it means.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load_one) begin
            count <= CNT_W'(1);
        end else if (clear) begin
            count <= '0;
        end else if (step) begin
            count <= count + CNT_W'(1);
        end
    end

endmodule

// File: rtl/jabwd_ctrl.sv
module jabwd_ctrl
    import jabwd_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int LIMIT_CYC = 4,
    parameter int LOCK_CYC  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_active,
    input  logic [CNT_W-1:0] count,
    output jab_state_e       state_d,
    output logic             load_one,
    output logic             clear,
    output logic             step,
    output logic             trip
);

    localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(LIMIT_CYC);
    localparam logic [CNT_W-1:0] LOCK_V  = CNT_W'(LOCK_CYC);

    jab_state_e state_q;
    logic       at_limit;
    logic       lock_done;

    assign at_limit  = (count == LIMIT_V);
    assign lock_done = (count == LOCK_V);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ARMED;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and counter control
    always_comb begin
        state_d  = state_q;
        load_one = 1'b0;
        clear    = 1'b0;
        step     = 1'b0;
        trip     = 1'b0;
        unique case (state_q)
            ST_ARMED: begin
                if (tx_active) begin            // START
                    state_d  = ST_COUNTING;
                    load_one = 1'b1;
                end
            end
            ST_COUNTING: begin
                if (!tx_active) begin           // ABORT
                    state_d = ST_ARMED;
                    clear   = 1'b1;
                end else if (at_limit) begin    // TRIP
                    state_d  = ST_LOCKOUT;
                    load_one = 1'b1;
                    trip     = 1'b1;
                end else begin
                    step = 1'b1;
                end
            end
            ST_LOCKOUT: begin
                if (lock_done) begin            // RELEASE or PARK
                    clear   = 1'b1;
                    state_d = tx_active ? ST_HOLDOFF : ST_ARMED;
                end else begin
                    step = 1'b1;
                end
            end
            ST_HOLDOFF: begin
                if (!tx_active) begin           // REARM
                    state_d = ST_ARMED;
                end
            end
            default: begin
                state_d = ST_ARMED;
            end
        endcase
    end

endmodule

// File: rtl/jabwd_out_stage.sv
module jabwd_out_stage
    import jabwd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  jab_state_e state_d,
    input  logic       trip,
    output logic       tx_enable,
    output logic       jabber_evt
);

    // Registered outputs, aligned with the state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_enable  <= 1'b1;
            jabber_evt <= 1'b0;
        end else begin
            tx_enable  <= (state_d != ST_LOCKOUT);
            jabber_evt <= trip;
        end
    end

endmodule

// File: rtl/tx_jabber_watchdog.sv
module tx_jabber_watchdog
    import jabwd_pkg::*;
#(
    parameter int CLK_HZ    = 25_000_000,
    parameter int LIMIT_MS  = 2,
    parameter int LOCK_MS   = 16,
    parameter int LIMIT_CYC = (CLK_HZ / 1000) * LIMIT_MS,
    parameter int LOCK_CYC  = (CLK_HZ / 1000) * LOCK_MS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_active,
    output logic tx_enable,
    output logic jabber_evt
);

    localparam int SPAN_MAX = max_int(LIMIT_CYC, LOCK_CYC);
    localparam int CNT_W    = bits_for(SPAN_MAX);

    logic [CNT_W-1:0] count;
    jab_state_e       state_d;
    logic             load_one;
    logic             clear;
    logic             step;
    logic             trip;

    jabwd_span_counter #(
        .CNT_W (CNT_W)
    ) span_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_one (load_one),
        .clear    (clear),
        .step     (step),
        .count    (count)
    );

    jabwd_ctrl #(
        .CNT_W     (CNT_W),
        .LIMIT_CYC (LIMIT_CYC),
        .LOCK_CYC  (LOCK_CYC)
    ) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_active (tx_active),
        .count     (count),
        .state_d   (state_d),
        .load_one  (load_one),
        .clear     (clear),
        .step      (step),
        .trip      (trip)
    );

    jabwd_out_stage out_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .state_d    (state_d),
        .trip       (trip),
        .tx_enable  (tx_enable),
        .jabber_evt (jabber_evt)
    );

endmodule

// File: rtl/tx_jabber_watchdog_chk.sv
module tx_jabber_watchdog_chk #(
    parameter int LIMIT_CYC = 4,
    parameter int LOCK_CYC  = 4
) (
    input logic clk,
    input logic rst_n,
    input logic tx_active,
    input logic tx_enable,
    input logic jabber_evt
);

    localparam int HI_SAT = LIMIT_CYC + 2;

    int hi_run;
    int off_run;

    // Consecutive high samples of tx_active, saturating past the trip point
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_run <= 0;
        end else if (!tx_active) begin
            hi_run <= 0;
        end else if (hi_run < HI_SAT) begin
            hi_run <= hi_run + 1;
        end
    end

    // Consecutive low samples of tx_enable
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_run <= 0;
        end else if (tx_enable) begin
            off_run <= 0;
        end else begin
            off_run <= off_run + 1;
        end
    end

    assert_trip_at_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        jabber_evt |-> (hi_run == LIMIT_CYC + 1));

    assert_no_retrigger_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_run > LIMIT_CYC + 1) |-> !jabber_evt);

    assert_pulse_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        jabber_evt |=> !jabber_evt);

    assert_pulse_gates_R4: assert property (@(posedge clk) disable iff (!rst_n)
        jabber_evt |-> !tx_enable);

    assert_gate_only_on_trip_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_enable) |-> jabber_evt);

    assert_lock_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_enable && (off_run != 0)) |-> (off_run == LOCK_CYC));

    assert_lock_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_enable |-> (off_run < LOCK_CYC));

endmodule

bind tx_jabber_watchdog tx_jabber_watchdog_chk #(
    .LIMIT_CYC (LIMIT_CYC),
    .LOCK_CYC  (LOCK_CYC)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_active  (tx_active),
    .tx_enable  (tx_enable),
    .jabber_evt (jabber_evt)
);

// File: tb/tx_jabber_watchdog_tb_top.sv
module tx_jabber_watchdog_tb_top;

    localparam int LIM = 5;
    localparam int LCK = 7;

    logic clk       = 1'b0;
    logic rst_n     = 1'b0;
    logic tx_active = 1'b0;
    logic tx_enable;
    logic jabber_evt;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    tx_jabber_watchdog #(
        .LIMIT_CYC (LIM),
        .LOCK_CYC  (LCK)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_active  (tx_active),
        .tx_enable  (tx_enable),
        .jabber_evt (jabber_evt)
    );

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
        end
    endtask

    // Drive L high samples then gap low samples, starting from ARMED at a falling edge.
    // Expected values follow from L and the sample index k alone.
    task automatic run_burst(input int L, input int gap, input string force_tag);
        bit    tripped;
        bit    exp_evt;
        bit    exp_en;
        string tag;
        tripped = (L > LIM);
        for (int k = 1; k <= L + gap; k++) begin
            tx_active = (k <= L);
            @(posedge clk);
            @(negedge clk);
            exp_evt = tripped && (k == LIM + 1);
            exp_en  = !(tripped && (k >= LIM + 1) && (k <= LIM + LCK));
            if (force_tag != "")                          tag = force_tag;
            else if (!tripped || k <= LIM)                tag = "R2";
            else if (k == LIM + 1)                        tag = "R3";
            else if (k <= LIM + LCK)                      tag = "R5";
            else if (L > LIM + LCK && k <= L)             tag = "R7";
            else                                          tag = "R5";
            chk(tag, $sformatf("tx_enable L=%0d k=%0d", L, k), tx_enable, exp_en);
            chk(tripped ? "R4" : tag, $sformatf("jabber_evt L=%0d k=%0d", L, k), jabber_evt, exp_evt);
        end
    endtask

    function automatic int gap_for(input int L);
        int need;
        need = LIM + LCK + 1 - L;
        return (L > LIM) ? ((need > 1 ? need : 1) + 2) : 2;
    endfunction

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog timeout: actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "tx_enable in reset", tx_enable, 1'b1);
        chk("R1", "jabber_evt in reset", jabber_evt, 1'b0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", "tx_enable after reset", tx_enable, 1'b1);
        chk("R1", "jabber_evt after reset", jabber_evt, 1'b0);

        // R2 R3 R4 R5 R7: sweep of burst lengths
        for (int L = 1; L <= 40; L++) begin
            run_burst(L, gap_for(L), "");
        end

        // R6: a single low sample restarts the count
        run_burst(LIM, 1, "R6");
        run_burst(LIM, 1, "R6");
        run_burst(LIM - 1, 1, "R6");
        run_burst(LIM, 1, "R6");
        run_burst(LIM + 1, gap_for(LIM + 1), "");

        // R7: stuck high, one low sample, then an immediate new trip
        run_burst(3 * (LIM + LCK), 1, "");
        run_burst(LIM + 1, gap_for(LIM + 1), "R7");

        // R1: reset during lockout reopens the gate at once
        for (int k = 1; k <= LIM + 3; k++) begin
            tx_active = 1'b1;
            @(posedge clk);
            @(negedge clk);
        end
        chk("R3", "tx_enable in lockout before reset", tx_enable, 1'b0);
        rst_n     = 1'b0;
        tx_active = 1'b0;
        #1;
        chk("R1", "tx_enable on reset in lockout", tx_enable, 1'b1);
        chk("R1", "jabber_evt on reset in lockout", jabber_evt, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "tx_enable after lockout reset", tx_enable, 1'b1);
        run_burst(LIM + 1, gap_for(LIM + 1), "");
        run_burst(LIM, 2, "R2");

        summary();
        $finish;
    end

endmodule